// File: doc/BRIEF.md
# Posit Word Unpacker

This block turns a tapered-precision posit word into the normalised form that arithmetic units consume: a separate sign bit, a signed binary scale and a left-aligned fraction whose hidden leading one is dropped. It is built for a datapath that sits between a posit register file and adders, multipliers or an accumulator. The format is chosen by two parameters: the word width `NBITS` and the exponent width `ES`. The output widths `SBITS` and `FBITS` are set separately.

A word is taken in on any cycle where `in_valid` is high. The decoded result shows on the registered outputs one clock later, with `out_valid` high. Negative words are folded to their magnitude by two's complement negation before any field is read. The variable-length regime run is then measured and converted to a power of `useed = 2^(2^ES)`. The exponent and fraction bits are pulled from whatever bits remain after the run. Zero and Not-a-Real each have their own output flag.

Top module: `posit_unpack`

## Requirements
- R1: `out_sign` equals bit NBITS-1 of the accepted word. A negative word is negated in two's complement before its fields are read, so a word and its negation give the same scale and fraction.
- R2: The all-zero word sets `out_zero`=1 and `out_nar`=0, with sign, scale and fraction all zero.
- R3: The word with only bit NBITS-1 set sets `out_nar`=1 and `out_zero`=0, with sign, scale and fraction all zero.
- R4: The regime is the run of equal bits that starts at bit NBITS-2 and ends at the first opposite bit or at bit 0. A run of m ones gives k=m-1 and a run of m zeros gives k=-m. With ES=0 the scale equals k.
- R5: The scale is k·2^ES+e as a signed SBITS-bit integer, where e is the exponent field. Its magnitude never exceeds (NBITS-2)·2^ES.
- R6: The exponent field is the ES bits that follow the bit ending the run. Any exponent bit past bit 0 reads as zero.
- R7: The fraction is the bits after the exponent, placed MSB-first at `out_frac[FBITS-1]` with zeros padded on the right. The hidden one is not included.
- R8: `out_valid` is high exactly one clock after a cycle with `in_valid` high. All other outputs keep their values through cycles with `in_valid` low.
- R9: A synchronous active-low `rst_n` clears every output to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accept `in_word` this cycle |
| in_word | input | NBITS | Posit encoding |
| out_valid | output | 1 | A decoded result is on the outputs |
| out_zero | output | 1 | Word was zero |
| out_nar | output | 1 | Word was Not-a-Real |
| out_sign | output | 1 | Sign of the value |
| out_scale | output | SBITS | Signed power-of-two scale |
| out_frac | output | FBITS | Fraction bits below the hidden one |

## Verification
The bench builds two copies side by side from the same stimulus. One is an 8-bit word with no exponent bits (SBITS=5, FBITS=5), where the scale equals the regime value, so the run-length decoding is seen directly. The other is an 8-bit word with one exponent bit (SBITS=6, FBITS=4), which exercises the exponent shift and exponent bits cut off at the end of the word. Both widths are small, so all 256 encodings of each can be walked through in full, covering every regime length, both signs and both special words. Random words with idle gaps follow, to show that the outputs hold.

// File: rtl/posit_unpack.sv
module posit_unpack #(
  parameter int NBITS = 8,
  parameter int ES    = 0,
  parameter int SBITS = 5,
  parameter int FBITS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [NBITS-1:0] in_word,
  output logic             out_valid,
  output logic             out_zero,
  output logic             out_nar,
  output logic             out_sign,
  output logic [SBITS-1:0] out_scale,
  output logic [FBITS-1:0] out_frac
);
  localparam int RW  = NBITS - 1;
  localparam int XW  = RW + ES + FBITS;
  localparam int CW  = $clog2(NBITS) + 2;
  localparam int ESW = (ES > 0) ? ES : 1;

  logic             neg, is_zero, is_nar, lead;
  logic [NBITS-1:0] mag;
  logic [RW-1:0]    body;
  logic [CW-1:0]    run, skip;
  logic [XW-1:0]    ext, sh;
  logic [ESW-1:0]   ex;
  logic [FBITS-1:0] frac;
  logic [SBITS-1:0] scale;
  logic             unused_tail;

  assign neg     = in_word[NBITS-1];
  assign is_zero = (in_word == '0);
  assign is_nar  = (in_word == {1'b1, {RW{1'b0}}});
  assign mag     = neg ? -in_word : in_word;
  assign body    = mag[RW-1:0];
  assign lead    = body[RW-1];

  always_comb begin
    logic stop;
    stop = 1'b0;
    run  = '0;
    for (int i = RW - 1; i >= 0; i--) begin
      if (!stop && body[i] == lead) run = run + 1'b1;
      else stop = 1'b1;
    end
  end

  assign skip = run + 1'b1;
  assign ext  = {body, {(ES + FBITS){1'b0}}};
  assign sh   = ext << skip;
  assign frac = sh[XW-1-ES -: FBITS];

  generate
    if (ES > 0) begin : g_exp
      assign ex = sh[XW-1 -: ES];
    end else begin : g_noexp
      assign ex = '0;
    end
  endgenerate

  always_comb begin
    int k, s;
    k = lead ? int'(run) - 1 : -int'(run);
    s = k * (2 ** ES) + int'(ex);
    scale = SBITS'(s);
  end

  assign unused_tail = ^{sh[RW-1:0], mag[NBITS-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_zero  <= 1'b0;
      out_nar   <= 1'b0;
      out_sign  <= 1'b0;
      out_scale <= '0;
      out_frac  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_zero <= is_zero;
        out_nar  <= is_nar;
        if (is_zero || is_nar) begin
          out_sign  <= 1'b0;
          out_scale <= '0;
          out_frac  <= '0;
        end else begin
          out_sign  <= neg;
          out_scale <= scale;
          out_frac  <= frac;
        end
      end
    end
  end
endmodule

// File: rtl/posit_unpack_chk.sv
module posit_unpack_chk #(
  parameter int NBITS = 8,
  parameter int ES    = 0,
  parameter int SBITS = 5,
  parameter int FBITS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [NBITS-1:0] in_word,
  input logic             out_valid,
  input logic             out_zero,
  input logic             out_nar,
  input logic             out_sign,
  input logic [SBITS-1:0] out_scale,
  input logic [FBITS-1:0] out_frac
);
  localparam int SMAX = (NBITS - 2) * (2 ** ES);
  localparam logic [NBITS-1:0] NAR_W = {1'b1, {(NBITS-1){1'b0}}};

  p_sign_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word != '0 && in_word != NAR_W) |=> out_sign == $past(in_word[NBITS-1]));

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word == '0) |=> (out_zero && !out_nar && out_scale == '0 && out_frac == '0));

  p_nar_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word == NAR_W) |=> (out_nar && !out_zero && !out_sign && out_scale == '0));

  p_scale_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zero && !out_nar) |->
      ($signed(out_scale) <= SMAX && $signed(out_scale) >= -SMAX));

  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_scale) && $stable(out_frac) && $stable(out_sign)));

  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !out_zero && !out_nar && out_scale == '0 && out_frac == '0));
endmodule

bind posit_unpack posit_unpack_chk #(.NBITS(NBITS), .ES(ES), .SBITS(SBITS), .FBITS(FBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .out_zero(out_zero), .out_nar(out_nar),
  .out_sign(out_sign), .out_scale(out_scale), .out_frac(out_frac)
);

// File: tb/sim_posit_unpack.sv
`timescale 1ns/1ps
module sim_posit_unpack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_word = '0;
  always #5 clk = ~clk;

  logic       v0, z0, n0, s0, v1, z1, n1, s1;
  logic [4:0] sc0, fr0;
  logic [5:0] sc1;
  logic [3:0] fr1;

  posit_unpack #(.NBITS(8), .ES(0), .SBITS(5), .FBITS(5)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(v0), .out_zero(z0), .out_nar(n0), .out_sign(s0),
    .out_scale(sc0), .out_frac(fr0));

  posit_unpack #(.NBITS(8), .ES(1), .SBITS(6), .FBITS(4)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .out_valid(v1), .out_zero(z1), .out_nar(n1), .out_sign(s1),
    .out_scale(sc1), .out_frac(fr1));

  int total = 0;
  int bad = 0;
  int ez[2], en[2], es_[2], esc[2], efr[2];

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_dec(input int n, input int es, input int fb, input int w,
                                  output int z, output int na, output int sg,
                                  output int sc, output int fr);
    int v, lead, m, p, k, e;
    v = w & ((1 << n) - 1);
    z = (v == 0);
    na = (v == (1 << (n - 1)));
    sg = 0; sc = 0; fr = 0;
    if (z != 0 || na != 0) return;
    sg = (v >> (n - 1)) & 1;
    if (sg != 0) v = ((1 << n) - v) & ((1 << n) - 1);
    lead = (v >> (n - 2)) & 1;
    m = 0;
    p = n - 2;
    while (p >= 0 && ((v >> p) & 1) == lead) begin m++; p--; end
    p--;
    k = (lead != 0) ? m - 1 : -m;
    e = 0;
    for (int j = 0; j < es; j++) begin e = e * 2 + ((p >= 0) ? ((v >> p) & 1) : 0); p--; end
    fr = 0;
    for (int j = 0; j < fb; j++) begin fr = fr * 2 + ((p >= 0) ? ((v >> p) & 1) : 0); p--; end
    sc = k * (1 << es) + e;
  endfunction

  task automatic step(input logic [7:0] w, input logic v);
    @(negedge clk);
    in_word = w;
    in_valid = v;
    @(negedge clk);
    if (v) begin
      ref_dec(8, 0, 5, int'(w), ez[0], en[0], es_[0], esc[0], efr[0]);
      ref_dec(8, 1, 4, int'(w), ez[1], en[1], es_[1], esc[1], efr[1]);
    end
    chk("R8 out_valid u0", int'(v0), int'(v));
    chk("R8 out_valid u1", int'(v1), int'(v));
    chk(v ? "R2 zero u0" : "R8 hold zero u0", int'(z0), ez[0]);
    chk(v ? "R3 nar u0"  : "R8 hold nar u0",  int'(n0), en[0]);
    chk(v ? "R1 sign u0" : "R8 hold sign u0", int'(s0), es_[0]);
    chk(v ? "R4 scale u0" : "R8 hold scale u0", int'($signed(sc0)), esc[0]);
    chk(v ? "R7 frac u0" : "R8 hold frac u0", int'(fr0), efr[0]);
    chk(v ? "R2 zero u1" : "R8 hold zero u1", int'(z1), ez[1]);
    chk(v ? "R3 nar u1"  : "R8 hold nar u1",  int'(n1), en[1]);
    chk(v ? "R1 sign u1" : "R8 hold sign u1", int'(s1), es_[1]);
    chk(v ? "R5 scale u1" : "R8 hold scale u1", int'($signed(sc1)), esc[1]);
    chk(v ? "R7 frac u1" : "R8 hold frac u1", int'(fr1), efr[1]);
  endtask

  task automatic chk_cleared(input string tag);
    chk(tag, int'({v0, z0, n0, s0, sc0, fr0}), 0);
    chk(tag, int'({v1, z1, n1, s1, sc1, fr1}), 0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int i = 0; i < 2; i++) begin ez[i] = 0; en[i] = 0; es_[i] = 0; esc[i] = 0; efr[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_cleared("R9 reset state");
    rst_n = 1'b1;

    // R2 / R3 directed specials
    step(8'h00, 1'b1);
    chk("R2 zero flag", int'(z0 & z1 & ~n0 & ~n1), 1);
    step(8'h80, 1'b1);
    chk("R3 nar flag", int'(n0 & n1 & ~z0 & ~z1), 1);

    // R5 / R6 extremes of the one-exponent-bit configuration
    step(8'h7F, 1'b1);
    chk("R5 maxpos scale", int'($signed(sc1)), 12);
    step(8'h7E, 1'b1);
    chk("R6 exponent past end", int'($signed(sc1)), 10);
    step(8'h01, 1'b1);
    chk("R5 minpos scale", int'($signed(sc1)), -12);
    chk("R4 minpos regime", int'($signed(sc0)), -6);

    // R1 negation symmetry
    step(8'h4C, 1'b1);
    begin
      int sa, fa;
      sa = int'($signed(sc1)); fa = int'(fr1);
      step(8'hB4, 1'b1);
      chk("R1 negated scale", int'($signed(sc1)), sa);
      chk("R1 negated frac", int'(fr1), fa);
      chk("R1 negated sign", int'(s1), 1);
    end

    // exhaustive sweep of all encodings
    for (int w = 0; w < 256; w++) step(8'(w), 1'b1);

    // random words with idle gaps (R8 hold)
    for (int i = 0; i < 400; i++) step(8'($urandom), ($urandom % 3) != 0);

    // R9 reset during traffic
    @(negedge clk);
    in_word = 8'h5A;
    in_valid = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    chk_cleared("R9 mid-run reset");
    rst_n = 1'b1;
    in_valid = 1'b0;
    for (int i = 0; i < 2; i++) begin ez[i] = 0; en[i] = 0; es_[i] = 0; esc[i] = 0; efr[i] = 0; end
    step(8'h33, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule